// File: doc/BRIEF.md
# Flow-Controlled Write Sink

This block takes words pushed by a bus-side producer and holds them in a small internal buffer. A slower consumer drains the buffer at its own pace through a valid/ready handshake. The producer offers a word by raising a write-enable together with the data. The sink reports back-pressure through a registered full flag. That flag is timed so that the producer may treat a low flag as permission to commit a write. The flag can rise only on the clock after a write, so the producer never sees it rise without cause.

The full flag rises once a write leaves exactly one free slot. A write issued in the same cycle that the flag first goes high therefore still fits. A write that finds the buffer completely occupied is discarded and raises a sticky overflow flag.

A session input marks the producer channel as active. Dropping it empties the buffer so that the next session starts clean. A global quiesce input clears all state, including the overflow flag. Everything runs on one clock.

Top module: `wr_flow_sink`

## Requirements
- R1: Every stored word reaches `rd_data_o` in arrival order. The oldest word is shown while `rd_valid_o` is high, and it is removed on a clock edge where `rd_valid_o` and `rd_ready_i` are both high.
- R2: `wr_full_o` goes from low to high only on the edge that ends a cycle with `wr_en_i` high. That write must bring the occupancy to DEPTH-1 or more.
- R3: `wr_full_o` goes from high to low, in any cycle, on the edge that brings the occupancy to DEPTH-2 or less. It stays high while the occupancy is DEPTH-1 or DEPTH.
- R4: A write accepted while the occupancy is DEPTH-1 is stored, even though `wr_full_o` is already high. This covers the write in the first cycle of full.
- R5: A write while the buffer holds DEPTH words is discarded, and the buffer contents do not change. `overflow_o` goes high on the next edge and stays high until quiesce or reset.
- R6: While `wr_open_i` is low, the buffer is cleared: after the next edge `rd_valid_o` and `wr_full_o` are low. Writes during that time are ignored, and `overflow_o` keeps its value.
- R7: A cycle with `quiesce_i` high clears the buffer, `wr_full_o` and `overflow_o` at the next edge.
- R8: While `rst_ni` is low, `rd_valid_o`, `wr_full_o` and `overflow_o` are low.
- R9: A write and a removal on the same edge leave the occupancy unchanged. With the consumer always ready, a stream of back-to-back writes never raises `wr_full_o`.
- R10: A write into an empty buffer makes `rd_valid_o` high after that edge, with the written word on `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quiesce_i | input | 1 | Synchronous global clear |
| wr_open_i | input | 1 | Producer session active; low clears the buffer |
| wr_en_i | input | 1 | Producer write-enable |
| wr_data_i | input | DATA_W | Producer data (8, 16 or 32 bits) |
| wr_full_o | output | 1 | Registered back-pressure flag |
| rd_data_o | output | DATA_W | Oldest stored word |
| rd_valid_o | output | 1 | Buffer not empty |
| rd_ready_i | input | 1 | Consumer accepts the shown word |
| overflow_o | output | 1 | Sticky flag for a discarded write |

## Verification
Every result of this block is registered, so each one is due exactly one edge after its cause. A write shows up on `rd_valid_o`, `rd_data_o` and `wr_full_o` after the edge that stores it. A removal lowers the full flag after the edge that pops the word. A clear or quiesce empties the buffer after its edge.

The bench changes its inputs on falling edges and reads the flags on the next falling edge, one edge after the stimulus. The consumer model sets the ready input on a falling edge. In that same cycle it compares the shown word against the head of the expected queue, because that word is the one the coming edge removes. Full-flag timing is probed with the consumer stalled, so the occupancy at each edge is known exactly.

// File: rtl/wr_sink_pkg.sv
package wr_sink_pkg;

  function automatic int unsigned idx_width(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned cnt_width(int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/sink_ptr.sv
module sink_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = wr_sink_pkg::idx_width(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (inc_i)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/sink_store.sv
module sink_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = wr_sink_pkg::idx_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == IDX_W'(i)) slot_q[i] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];

endmodule

// File: rtl/sink_level.sv
module sink_level #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = wr_sink_pkg::cnt_width(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic quiesce_i,
  input  logic wr_req_i,
  input  logic pop_req_i,
  output logic accept_o,
  output logic pop_o,
  output logic avail_o,
  output logic full_o,
  output logic ovf_o
);

  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HI_MARK = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, ovf_q;
  logic             accept, pop, drop;

  assign accept = wr_req_i & ~clr_i & (cnt_q != LIMIT);
  assign drop   = wr_req_i & ~clr_i & (cnt_q == LIMIT);
  assign pop    = pop_req_i & ~clr_i & (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q + CNT_W'(accept) - CNT_W'(pop);
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      // full may drop any time, but rise only together with a write
      if (clr_i || cnt_d < HI_MARK) full_q <= 1'b0;
      else if (accept)              full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (quiesce_i) ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
  end

  assign accept_o = accept;
  assign pop_o    = pop;
  assign avail_o  = (cnt_q != '0);
  assign full_o   = full_q;
  assign ovf_o    = ovf_q;

  p_full_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(wr_req_i));

  p_full_room_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (cnt_q >= HI_MARK));

  p_full_at_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT) |-> full_q);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !quiesce_i) |=> ovf_q);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !full_q);

endmodule

// File: rtl/wr_flow_sink.sv
module wr_flow_sink #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              quiesce_i,
  input  logic              wr_open_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              overflow_o
);

  localparam int unsigned IDX_W = wr_sink_pkg::idx_width(DEPTH);

  logic             clr;
  logic             accept, pop, avail;
  logic [IDX_W-1:0] wptr, rptr;

  // session end and quiesce both empty the buffer
  assign clr = quiesce_i | ~wr_open_i;

  sink_level #(.DEPTH(DEPTH)) i_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .quiesce_i (quiesce_i),
    .wr_req_i  (wr_en_i),
    .pop_req_i (rd_ready_i),
    .accept_o  (accept),
    .pop_o     (pop),
    .avail_o   (avail),
    .full_o    (wr_full_o),
    .ovf_o     (overflow_o)
  );

  sink_ptr #(.DEPTH(DEPTH)) i_wptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (accept),
    .ptr_o  (wptr)
  );

  sink_ptr #(.DEPTH(DEPTH)) i_rptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (pop),
    .ptr_o  (rptr)
  );

  sink_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (wptr),
    .wdata_i (wr_data_i),
    .raddr_i (rptr),
    .rdata_o (rd_data_o)
  );

  assign rd_valid_o = avail;

  p_valid_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_full_o && !clr) |=> rd_valid_o);

  p_reset_state_r8: assert property (@(posedge clk_i)
    !rst_ni |-> !rd_valid_o && !wr_full_o && !overflow_o);

endmodule

// File: tb/test_wr_flow_sink.sv
`timescale 1ns/1ps
module test_wr_flow_sink;

  localparam int DW    = 32;
  localparam int DEPTH = 8;

  logic          clk_i      = 1'b0;
  logic          rst_ni     = 1'b0;
  logic          quiesce_i  = 1'b0;
  logic          wr_open_i  = 1'b1;
  logic          wr_en_i    = 1'b0;
  logic [DW-1:0] wr_data_i  = '0;
  logic          rd_ready_i = 1'b0;
  logic          wr_full_o, rd_valid_o, overflow_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  bit tog = 1'b0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  wr_flow_sink #(.DATA_W(DW), .DEPTH(DEPTH)) i_wr_flow_sink (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .quiesce_i  (quiesce_i),
    .wr_open_i  (wr_open_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .wr_full_o  (wr_full_o),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .overflow_o (overflow_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // monitor: sets ready for the coming edge and checks the word that edge removes
  always @(negedge clk_i) begin
    if (!rst_ni) rd_ready_i = 1'b0;
    else begin
      case (ready_mode)
        0:       rd_ready_i = 1'b0;
        1:       rd_ready_i = 1'b1;
        default: begin tog = ~tog; rd_ready_i = tog; end
      endcase
      if (rd_valid_o && rd_ready_i) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected word", rd_data_o, '0);
        else begin
          chk(rd_data_o == exp_q[0], "R1 order", rd_data_o, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // driver: called at a falling edge, returns at the next one
  task automatic do_write(input logic [DW-1:0] d, input bit keep);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    if (keep) exp_q.push_back(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic push_flow(input logic [DW-1:0] d);
    while (wr_full_o) @(negedge clk_i);
    do_write(d, 1'b1);
  endtask

  task automatic set_mode(input int m);
    @(posedge clk_i);
    ready_mode = m;
    @(negedge clk_i);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 200 && (exp_q.size() != 0 || rd_valid_o); k++) @(negedge clk_i);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(!rd_valid_o, "R8 valid in reset", rd_valid_o, 0);
    chk(!wr_full_o,  "R8 full in reset",  wr_full_o, 0);
    chk(!overflow_o, "R8 overflow in reset", overflow_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // consumer stalled: fill and probe full timing
    for (int i = 0; i < 6; i++) begin
      do_write(32'hA000 + i, 1'b1);
      if (i == 0) begin
        chk(rd_valid_o, "R10 valid after first write", rd_valid_o, 1);
        chk(rd_data_o == 32'hA000, "R10 data shown", rd_data_o, 32'hA000);
      end
    end
    chk(!wr_full_o, "R3 low at DEPTH-2", wr_full_o, 0);
    do_write(32'hA006, 1'b1);
    chk(wr_full_o, "R2 rises after write to DEPTH-1", wr_full_o, 1);
    do_write(32'hA007, 1'b1);
    chk(!overflow_o, "R4 write in full cycle kept", overflow_o, 0);
    do_write(32'hBAD0, 1'b0);
    chk(overflow_o, "R5 overflow set", overflow_o, 1);
    chk(wr_full_o, "R5 full stays high", wr_full_o, 1);

    set_mode(1);
    @(negedge clk_i);
    chk(wr_full_o, "R3 holds at DEPTH-1", wr_full_o, 1);
    @(negedge clk_i);
    chk(!wr_full_o, "R3 falls at DEPTH-2", wr_full_o, 0);
    drain("R4 all words incl. last slot delivered");
    chk(!rd_valid_o, "R5 dropped word not stored", rd_valid_o, 0);
    chk(overflow_o, "R5 overflow sticky", overflow_o, 1);

    // R9: streaming with consumer always ready
    begin
      bit saw_full = 1'b0;
      for (int i = 0; i < 20; i++) begin
        do_write(32'hC000 + i, 1'b1);
        if (wr_full_o) saw_full = 1'b1;
      end
      chk(!saw_full, "R9 no full while streaming", saw_full, 0);
    end
    drain("R9 stream delivered");

    // flow-controlled burst against a half-rate consumer
    set_mode(2);
    for (int i = 0; i < 24; i++) push_flow(32'hD000 + i);
    drain("R1 paced burst delivered");

    // R6: session end clears the buffer
    set_mode(0);
    for (int i = 0; i < 3; i++) do_write(32'hE000 + i, 1'b0);
    chk(rd_valid_o, "R6 words present before close", rd_valid_o, 1);
    wr_open_i = 1'b0;
    wr_en_i   = 1'b1;
    wr_data_i = 32'hEEEE;
    @(negedge clk_i);
    chk(!rd_valid_o, "R6 buffer cleared", rd_valid_o, 0);
    chk(!wr_full_o,  "R6 full cleared",   wr_full_o, 0);
    wr_open_i = 1'b1;
    wr_en_i   = 1'b0;
    @(negedge clk_i);
    chk(!rd_valid_o, "R6 write while closed ignored", rd_valid_o, 0);
    chk(overflow_o,  "R6 overflow kept", overflow_o, 1);
    do_write(32'hF00D, 1'b1);
    set_mode(1);
    drain("R6 new session delivers");

    // R7: quiesce clears everything
    set_mode(0);
    for (int i = 0; i < DEPTH + 1; i++) do_write(32'h1000 + i, 1'b0);
    chk(wr_full_o, "R7 full before quiesce", wr_full_o, 1);
    quiesce_i = 1'b1;
    @(negedge clk_i);
    quiesce_i = 1'b0;
    chk(!rd_valid_o, "R7 buffer cleared", rd_valid_o, 0);
    chk(!wr_full_o,  "R7 full cleared",   wr_full_o, 0);
    chk(!overflow_o, "R7 overflow cleared", overflow_o, 0);
    @(negedge clk_i);
    chk(!overflow_o, "R7 overflow stays clear", overflow_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule